// File: doc/BRIEF.md
# Transmit buffer window selector

This block decides which of three transmit message buffers appears in a shared 16-byte window of a byte-wide register bus. Software writes a mask into the select register. The register keeps only the lowest-numbered set bit of that mask, so a register read returns a one-hot value or zero. Window reads and writes then reach the storage of the chosen buffer only. The usual way to claim a free buffer is to copy the transmit-empty flags into the select register, which picks the lowest-numbered free buffer.

Window access is refused in two cases: when no buffer is selected, and when the selected buffer has its empty flag low while the transmitter has it queued. A refused read returns 0x00. A refused write changes nothing. Either kind raises a sticky error bit that software can read and clear. When the controller is in initialization mode (request and acknowledge both high), the select register is held at zero. It takes writes only when both of those signals are low.

Top module: `txwin_sel`

## Requirements
- R1: Reading address 0x10 returns the select register in bits 2..0, and bits 7..3 read as zero.
- R2: A write to address 0x10 stores only the lowest-numbered set bit of write data bits 2..0 (0x06 reads back 0x02, 0x07 reads back 0x01).
- R3: Writing 0x00, or a value whose set bits all lie in bits 7..3, to address 0x10 deselects every buffer.
- R4: Window addresses 0x00-0x0F (bus address bit 4 low) reach byte address[3:0] of the selected buffer when access is allowed, and each buffer keeps its own contents.
- R5: With no buffer selected, window reads return 0x00 and window writes are discarded.
- R6: If the selected buffer has tx_empty low and tx_queued high, window reads return 0x00 and writes are discarded. Access is allowed if either condition is absent.
- R7: Any refused window read or write sets a sticky error bit, read at bit 0 of address 0x11. Writing 1 to bit 0 of 0x11 clears it.
- R8: While init_req and init_ack are both high, the select register goes to zero on the next edge and ignores writes.
- R9: While exactly one of init_req and init_ack is high, writes to the select register are ignored and its value is held.
- R10: After reset the select register, the error bit and bus_rdata are zero.
- R11: Output tx_sel always shows the current select register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| bus_addr | input | 5 | Byte address: 0x00-0x0F window, 0x10 select, 0x11 error |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| tx_empty | input | 3 | Per-buffer transmit-empty flags |
| tx_queued | input | 3 | Per-buffer scheduled-for-transmission flags |
| tx_sel | output | 3 | One-hot selected buffer, zero if none |

## Verification
Every result appears one clock edge after its stimulus. bus_rdata is loaded on the edge that samples bus_re. tx_sel and the error bit change on the edge that samples the write or the refused access. The bench applies all inputs on the falling edge and compares on the next falling edge, which is half a period after the single register on each path has loaded. Reset release passes through a two-stage synchronizer, so the bench waits several cycles after deasserting rst_n before it issues the first access.

// File: rtl/txwin_pkg.sv
package txwin_pkg;
  localparam int NUM_BUF   = 3;
  localparam int BUF_BYTES = 16;
  localparam int DATA_W    = 8;
  localparam int BUF_AW    = $clog2(BUF_BYTES);
  localparam int ADDR_W    = BUF_AW + 1;
endpackage

// File: rtl/txwin_selreg.sv
module txwin_selreg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_req,
  input  logic         init_ack,
  input  logic         wr_en,
  input  logic [N-1:0] wr_mask,
  output logic [N-1:0] sel_o
);
  logic [N-1:0] sel_q, sel_d;
  logic         in_init, wr_open;

  assign in_init = init_req & init_ack;
  assign wr_open = ~init_req & ~init_ack;

  always_comb begin
    sel_d = sel_q;
    if (in_init)
      sel_d = '0;
    else if (wr_open && wr_en)
      sel_d = wr_mask & (~wr_mask + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/txwin_gate.sv
module txwin_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] sel,
  input  logic [N-1:0] tx_empty,
  input  logic [N-1:0] tx_queued,
  output logic         win_ok,
  output logic [N-1:0] win_sel
);
  logic busy;

  assign busy    = |(sel & ~tx_empty & tx_queued);
  assign win_ok  = (|sel) & ~busy;
  assign win_sel = win_ok ? sel : '0;
endmodule

// File: rtl/txwin_bufram.sv
module txwin_bufram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/txwin_sel.sv
module txwin_sel
  import txwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_BUF-1:0] tx_empty,
  input  logic [NUM_BUF-1:0] tx_queued,
  output logic [NUM_BUF-1:0] tx_sel
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] ERR_ADDR = ADDR_W'(BUF_BYTES + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic win_hit, sel_hit, err_hit;
  assign win_hit = ~bus_addr[ADDR_W-1];
  assign sel_hit = (bus_addr == SEL_ADDR);
  assign err_hit = (bus_addr == ERR_ADDR);

  // select register
  logic [NUM_BUF-1:0] sel;
  txwin_selreg #(.N(NUM_BUF)) u_selreg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .init_req(init_req),
    .init_ack(init_ack),
    .wr_en   (bus_we & sel_hit),
    .wr_mask (bus_wdata[NUM_BUF-1:0]),
    .sel_o   (sel)
  );
  assign tx_sel = sel;

  // access gate
  logic               win_ok;
  logic [NUM_BUF-1:0] win_sel;
  txwin_gate #(.N(NUM_BUF)) u_gate (
    .sel      (sel),
    .tx_empty (tx_empty),
    .tx_queued(tx_queued),
    .win_ok   (win_ok),
    .win_sel  (win_sel)
  );

  // buffer storage
  logic [DATA_W-1:0] buf_rd [NUM_BUF];
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    txwin_bufram #(.DEPTH(BUF_BYTES), .W(DATA_W)) u_ram (
      .clk  (clk),
      .we   (bus_we & win_hit & win_sel[g]),
      .addr (bus_addr[BUF_AW-1:0]),
      .wdata(bus_wdata),
      .rdata(buf_rd[g])
    );
  end

  logic [DATA_W-1:0] win_rdata;
  always_comb begin
    win_rdata = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (win_sel[i]) win_rdata = win_rdata | buf_rd[i];
  end

  // sticky error flag
  logic err_q, err_d;
  always_comb begin
    err_d = err_q;
    if (err_hit && bus_we && bus_wdata[0]) err_d = 1'b0;
    if (win_hit && (bus_we || bus_re) && !win_ok) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  // registered read data
  logic [DATA_W-1:0] rdata_q, rdata_d;
  always_comb begin
    if (win_hit)      rdata_d = win_rdata;
    else if (sel_hit) rdata_d = DATA_W'(sel);
    else if (err_hit) rdata_d = {{(DATA_W-1){1'b0}}, err_q};
    else              rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_re) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/txwin_sel_chk.sv
module txwin_sel_chk
  import txwin_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               init_req,
  input logic               init_ack,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_re,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_BUF-1:0] tx_empty,
  input logic [NUM_BUF-1:0] tx_queued,
  input logic [NUM_BUF-1:0] tx_sel
);
  logic win_rd;
  assign win_rd = bus_re & ~bus_addr[ADDR_W-1];

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_sel));

  a_r8_init_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (tx_sel == '0));

  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req != init_ack) |=> $stable(tx_sel));

  a_r5_desel_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && tx_sel == '0) |=> (bus_rdata == '0));

  a_r6_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && |(tx_sel & ~tx_empty & tx_queued)) |=> (bus_rdata == '0));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(BUF_BYTES)) |=> (bus_rdata[DATA_W-1:NUM_BUF] == '0));
endmodule

bind txwin_sel txwin_sel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .init_req (init_req),
  .init_ack (init_ack),
  .bus_addr (bus_addr),
  .bus_re   (bus_re),
  .bus_rdata(bus_rdata),
  .tx_empty (tx_empty),
  .tx_queued(tx_queued),
  .tx_sel   (tx_sel)
);

// File: tb/txwin_sel_tb_top.sv
`timescale 1ns/1ps
module txwin_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_req = 1'b0, init_ack = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] tx_empty = 3'b111, tx_queued = 3'b000;
  logic [2:0] tx_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txwin_sel dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_empty(tx_empty), .tx_queued(tx_queued), .tx_sel(tx_sel)
  );

  // vector: {rd, empty[3], queued[3], req[4], addr[5], data[8], exp[8]}
  localparam int NV = 26;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 3'b111, 3'b000, 4'd2,  5'h10, 8'h06, 8'h00}, // R2 write 0x06
    {1'b1, 3'b111, 3'b000, 4'd2,  5'h10, 8'h00, 8'h02}, // R2 reads 0x02
    {1'b0, 3'b111, 3'b000, 4'd4,  5'h03, 8'hA5, 8'h00}, // R4 buf1 byte3
    {1'b1, 3'b111, 3'b000, 4'd4,  5'h03, 8'h00, 8'hA5}, // R4
    {1'b0, 3'b111, 3'b000, 4'd2,  5'h10, 8'h07, 8'h00}, // R2 write 0x07
    {1'b1, 3'b111, 3'b000, 4'd2,  5'h10, 8'h00, 8'h01}, // R2 reads 0x01
    {1'b0, 3'b111, 3'b000, 4'd4,  5'h03, 8'h3C, 8'h00}, // R4 buf0 byte3
    {1'b1, 3'b111, 3'b000, 4'd4,  5'h03, 8'h00, 8'h3C}, // R4
    {1'b0, 3'b111, 3'b000, 4'd4,  5'h10, 8'h02, 8'h00}, // R4 back to buf1
    {1'b1, 3'b111, 3'b000, 4'd4,  5'h03, 8'h00, 8'hA5}, // R4 independent
    {1'b0, 3'b111, 3'b000, 4'd3,  5'h10, 8'hF8, 8'h00}, // R3 upper-only mask
    {1'b1, 3'b111, 3'b000, 4'd3,  5'h10, 8'h00, 8'h00}, // R3 none selected
    {1'b1, 3'b111, 3'b000, 4'd5,  5'h03, 8'h00, 8'h00}, // R5 read zero
    {1'b0, 3'b111, 3'b000, 4'd5,  5'h03, 8'h11, 8'h00}, // R5 write dropped
    {1'b1, 3'b111, 3'b000, 4'd7,  5'h11, 8'h00, 8'h01}, // R7 error set
    {1'b0, 3'b111, 3'b000, 4'd7,  5'h11, 8'h01, 8'h00}, // R7 clear
    {1'b1, 3'b111, 3'b000, 4'd7,  5'h11, 8'h00, 8'h00}, // R7 cleared
    {1'b0, 3'b111, 3'b000, 4'd5,  5'h10, 8'h02, 8'h00}, // R5 reselect buf1
    {1'b1, 3'b111, 3'b000, 4'd5,  5'h03, 8'h00, 8'hA5}, // R5 was not written
    {1'b1, 3'b101, 3'b010, 4'd6,  5'h03, 8'h00, 8'h00}, // R6 busy read zero
    {1'b0, 3'b101, 3'b010, 4'd6,  5'h03, 8'h77, 8'h00}, // R6 busy write
    {1'b1, 3'b101, 3'b010, 4'd7,  5'h11, 8'h00, 8'h01}, // R7 sticky
    {1'b1, 3'b111, 3'b010, 4'd6,  5'h03, 8'h00, 8'hA5}, // R6 empty set: ok
    {1'b1, 3'b101, 3'b000, 4'd6,  5'h03, 8'h00, 8'hA5}, // R6 not queued: ok
    {1'b0, 3'b111, 3'b000, 4'd7,  5'h11, 8'h01, 8'h00}, // R7 clear
    {1'b1, 3'b111, 3'b000, 4'd7,  5'h11, 8'h00, 8'h00}  // R7 cleared
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 rdata", bus_rdata, 8'h00);
    check("R10 tx_sel", {5'b0, tx_sel}, 8'h00);
    bus_rd(5'h10, rd); check("R10 select", rd, 8'h00);
    bus_rd(5'h11, rd); check("R10 error", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      @(negedge clk);
      tx_empty = v[30:28]; tx_queued = v[27:25];
      if (v[31]) begin
        bus_rd(v[20:16], rd);
        check($sformatf("R%0d vec%0d", v[24:21], i), rd, v[7:0]);
      end else begin
        bus_wr(v[20:16], v[15:8]);
      end
    end
    tx_empty = 3'b111; tx_queued = 3'b000;

    // R1 upper bits read zero
    bus_wr(5'h10, 8'hFF);
    bus_rd(5'h10, rd); check("R1 upper zero", rd, 8'h01);
    // R11 output mirrors register
    bus_wr(5'h10, 8'h04);
    check("R11 tx_sel", {5'b0, tx_sel}, 8'h04);

    // R8 init mode forces zero and ignores writes
    @(negedge clk); init_req = 1'b1; init_ack = 1'b1;
    @(negedge clk);
    check("R8 cleared", {5'b0, tx_sel}, 8'h00);
    bus_wr(5'h10, 8'h01);
    check("R8 write ignored", {5'b0, tx_sel}, 8'h00);

    // R9 transitional states hold value and ignore writes
    @(negedge clk); init_req = 1'b0; init_ack = 1'b0;
    bus_wr(5'h10, 8'h02);
    check("R9 open write", {5'b0, tx_sel}, 8'h02);
    @(negedge clk); init_req = 1'b1; init_ack = 1'b0;
    bus_wr(5'h10, 8'h04);
    check("R9 req only", {5'b0, tx_sel}, 8'h02);
    @(negedge clk); init_req = 1'b0; init_ack = 1'b1;
    bus_wr(5'h10, 8'h01);
    check("R9 ack only", {5'b0, tx_sel}, 8'h02);
    @(negedge clk); init_ack = 1'b0;
    bus_rd(5'h10, rd); check("R9 readback", rd, 8'h02);

    // R3 write of zero deselects
    bus_wr(5'h10, 8'h00);
    bus_rd(5'h10, rd); check("R3 zero write", rd, 8'h00);

    finish_run();
  end
endmodule